// File: doc/BRIEF.md
# Division Exception Entry Sequencer

This block sits beside an integer divider. When a divide instruction is issued, the block looks at its operands. A divisor of zero traps for both the unsigned and the signed form. Signed division also traps when the most negative value is divided by minus one, because the quotient cannot be represented. For every other operand pair the block stays idle and the divider continues unaided.

On a trap the block captures the context of the instruction: its address, the status register and the stack pointer. It then runs a fixed entry sequence over a single-word memory port:
1. Read the handler address from the vector table slot for division exceptions.
2. Push the status register.
3. Push the address of the faulting instruction.
4. Issue one PC load strobe carrying the handler address, together with the updated stack pointer. This is a plain jump with no delay slot.

The stack grows downward in 4-byte words. Each memory access is held until the memory raises a ready signal.

Top module: `div_exc_seq`

## Requirements
- R1: With `issue_valid` high and the block idle, a divisor of zero starts the entry sequence for both kinds (`issue_signed` 0 = unsigned, 1 = signed). `busy` goes high on the next cycle.
- R2: A signed divide of 0x80000000 by 0xFFFFFFFF starts the sequence. An unsigned divide of the same bit patterns does not, and `busy` stays low.
- R3: Any other operand pair starts nothing. `busy`, `mem_req`, `pc_load` and `sp_we` all stay low.
- R4: The first access is a read (`mem_we`=0) at the vector base captured at detection plus `VEC_NUM`*4.
- R5: The second access is a write of the captured status register to the captured stack pointer minus 4.
- R6: The third access is a write of the captured instruction address to the captured stack pointer minus 8.
- R7: In the cycle after the third access completes, `pc_load` pulses for exactly one cycle. In that cycle `pc_value` equals the word read in the first access, `sp_we` is high, and `sp_out` equals the captured stack pointer minus 8.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. An access completes only on a cycle with `mem_ready` high.
- R9: `busy` stays high from the cycle after detection through the `pc_load` cycle and drops on the next cycle. While `busy` is high, `issue_valid` is ignored.
- R10: After reset the block is idle, with `busy`, `mem_req`, `pc_load` and `sp_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A divide instruction is presented this cycle |
| issue_signed | input | 1 | 1 = signed divide, 0 = unsigned divide |
| dividend | input | DW | Dividend operand |
| divisor | input | DW | Divisor operand |
| insn_addr | input | DW | Start address of the divide instruction |
| sr_in | input | DW | Current status register value |
| sp_in | input | DW | Current stack pointer |
| vec_base | input | DW | Base address of the vector table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| pc_load | output | 1 | One-cycle strobe to load the handler PC |
| pc_value | output | DW | Handler address |
| sp_we | output | 1 | Stack pointer write-back strobe |
| sp_out | output | DW | New stack pointer |
| busy | output | 1 | Entry sequence in progress |

## Verification
The bench builds the block with a 32-bit word and `VEC_NUM` set to 5 instead of the default. A vector offset of 20 then shows that the table address follows the parameter rather than a hard-coded slot. At full 32-bit width both boundary patterns of R2 can be driven exactly: 0x80000000 as dividend and all-ones as divisor, for both kinds. Random memory latencies of zero to three cycles exercise both the same-cycle handshake and the hold behaviour.

// File: rtl/div_exc_pkg.sv
package div_exc_pkg;

    typedef enum logic {
        KIND_UNSIGNED = 1'b0,
        KIND_SIGNED   = 1'b1
    } div_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ZERO = 2'd1,
        CAUSE_OVF  = 2'd2
    } div_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_VEC   = 3'd1,
        ST_SR    = 3'd2,
        ST_PC    = 3'd3,
        ST_JUMP  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic req;
        logic we;
    } mem_ctl_t;

    localparam int WORD_BYTES = 4;

    function automatic mem_ctl_t ctl_for(seq_state_e st);
        mem_ctl_t c;
        c.req = (st == ST_VEC) || (st == ST_SR) || (st == ST_PC);
        c.we  = (st == ST_SR) || (st == ST_PC);
        return c;
    endfunction

endpackage

// File: rtl/div_exc_detect.sv
module div_exc_detect
    import div_exc_pkg::*;
#(
    parameter int DW = 32
) (
    input  div_kind_e          kind,
    input  logic [DW-1:0]      dividend,
    input  logic [DW-1:0]      divisor,
    output div_cause_e         cause
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MINUS_ONE = {DW{1'b1}};

    logic zero_div;
    logic ovf_div;

    always_comb begin
        zero_div = (divisor == '0);
        ovf_div  = (kind == KIND_SIGNED) && (dividend == MOST_NEG) && (divisor == MINUS_ONE);
        if (zero_div)
            cause = CAUSE_ZERO;
        else if (ovf_div)
            cause = CAUSE_OVF;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/div_exc_frame.sv
module div_exc_frame
    import div_exc_pkg::*;
#(
    parameter int DW      = 32,
    parameter int VEC_NUM = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          hcap,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] base_in,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] vec_addr,
    output logic [DW-1:0] sr_slot,
    output logic [DW-1:0] pc_slot,
    output logic [DW-1:0] sr_q,
    output logic [DW-1:0] pc_q,
    output logic [DW-1:0] handler_q
);
    localparam logic [DW-1:0] STEP    = DW'(WORD_BYTES);
    localparam logic [DW-1:0] VEC_OFS = DW'(VEC_NUM * WORD_BYTES);

    logic [DW-1:0] sp_q;
    logic [DW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q      <= '0;
            pc_q      <= '0;
            sp_q      <= '0;
            base_q    <= '0;
            handler_q <= '0;
        end else begin
            if (capture) begin
                sr_q   <= sr_in;
                pc_q   <= pc_in;
                sp_q   <= sp_in;
                base_q <= base_in;
            end
            if (hcap)
                handler_q <= rdata;
        end
    end

    always_comb begin
        vec_addr = base_q + VEC_OFS;
        sr_slot  = sp_q - STEP;
        pc_slot  = sr_slot - STEP;
    end
endmodule

// File: rtl/div_exc_ctrl.sv
module div_exc_ctrl
    import div_exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid,
    input  div_cause_e cause,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       capture,
    output logic       hcap,
    output logic       pc_load,
    output logic       busy
);
    seq_state_e nxt;

    always_comb begin
        capture = (state == ST_IDLE) && issue_valid && (cause != CAUSE_NONE);
        hcap    = (state == ST_VEC) && mem_ready;
        pc_load = (state == ST_JUMP);
        busy    = (state != ST_IDLE);
        nxt     = state;
        unique case (state)
            ST_IDLE: if (capture)   nxt = ST_VEC;
            ST_VEC:  if (mem_ready) nxt = ST_SR;
            ST_SR:   if (mem_ready) nxt = ST_PC;
            ST_PC:   if (mem_ready) nxt = ST_JUMP;
            ST_JUMP:                nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/div_exc_seq.sv
module div_exc_seq
    import div_exc_pkg::*;
#(
    parameter int DW      = 32,
    parameter int VEC_NUM = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic          issue_signed,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  logic [DW-1:0] insn_addr,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] vec_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          pc_load,
    output logic [DW-1:0] pc_value,
    output logic          sp_we,
    output logic [DW-1:0] sp_out,
    output logic          busy
);
    div_cause_e    cause;
    seq_state_e    state;
    logic          capture;
    logic          hcap;
    logic          strobe;
    logic [DW-1:0] vec_addr;
    logic [DW-1:0] sr_slot;
    logic [DW-1:0] pc_slot;
    logic [DW-1:0] sr_q;
    logic [DW-1:0] pc_q;
    logic [DW-1:0] handler_q;
    mem_ctl_t      ctl;

    div_exc_detect #(.DW(DW)) u_detect (
        .kind     (div_kind_e'(issue_signed)),
        .dividend (dividend),
        .divisor  (divisor),
        .cause    (cause)
    );

    div_exc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .cause       (cause),
        .mem_ready   (mem_ready),
        .state       (state),
        .capture     (capture),
        .hcap        (hcap),
        .pc_load     (strobe),
        .busy        (busy)
    );

    div_exc_frame #(.DW(DW), .VEC_NUM(VEC_NUM)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .hcap      (hcap),
        .sr_in     (sr_in),
        .pc_in     (insn_addr),
        .sp_in     (sp_in),
        .base_in   (vec_base),
        .rdata     (mem_rdata),
        .vec_addr  (vec_addr),
        .sr_slot   (sr_slot),
        .pc_slot   (pc_slot),
        .sr_q      (sr_q),
        .pc_q      (pc_q),
        .handler_q (handler_q)
    );

    always_comb begin
        ctl       = ctl_for(state);
        mem_req   = ctl.req;
        mem_we    = ctl.we;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_VEC: mem_addr = vec_addr;
            ST_SR: begin
                mem_addr  = sr_slot;
                mem_wdata = sr_q;
            end
            ST_PC: begin
                mem_addr  = pc_slot;
                mem_wdata = pc_q;
            end
            default: ;
        endcase
        pc_load  = strobe;
        pc_value = handler_q;
        sp_we    = strobe;
        sp_out   = pc_slot;
    end
endmodule

// File: rtl/div_exc_seq_chk.sv
module div_exc_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_valid,
    input logic          issue_signed,
    input logic [DW-1:0] divisor,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          pc_load,
    input logic          sp_we
);
    p_zero_start_r1: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy && divisor == '0) |=> busy);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy && !issue_signed && divisor != '0) |=> !busy);

    p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    p_sp_with_load_r7: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> sp_we);

    p_load_ends_r9: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);

    p_stay_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !pc_load) |=> busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !pc_load && !sp_we));
endmodule

bind div_exc_seq div_exc_seq_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .issue_signed (issue_signed),
    .divisor      (divisor),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .pc_load      (pc_load),
    .sp_we        (sp_we)
);

// File: tb/div_exc_seq_bench.sv
module div_exc_seq_bench;
    localparam int DW  = 32;
    localparam int VEC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 1'b0;
    logic          issue_signed = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic [DW-1:0] insn_addr = '0;
    logic [DW-1:0] sr_in = '0;
    logic [DW-1:0] sp_in = '0;
    logic [DW-1:0] vec_base = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          mem_req, mem_we, pc_load, sp_we, busy;
    logic [DW-1:0] mem_addr, mem_wdata, pc_value, sp_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    div_exc_seq #(.DW(DW), .VEC_NUM(VEC)) u_div_exc_seq (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_signed(issue_signed),
        .dividend(dividend), .divisor(divisor), .insn_addr(insn_addr), .sr_in(sr_in),
        .sp_in(sp_in), .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .pc_load(pc_load), .pc_value(pc_value), .sp_we(sp_we),
        .sp_out(sp_out), .busy(busy)
    );

    function automatic bit expect_trap(bit sgn, logic [DW-1:0] a, logic [DW-1:0] b);
        return (b == '0) || (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic serve(bit exp_we, logic [DW-1:0] exp_addr, logic [DW-1:0] exp_wdata,
                         logic [DW-1:0] rd, string req);
        int n = 0;
        while (!mem_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(mem_req == 1'b1, req, "mem_req", 32'(mem_req), 32'd1);
        chk(mem_we == exp_we, req, "mem_we", 32'(mem_we), 32'(exp_we));
        chk(mem_addr == exp_addr, req, "mem_addr", mem_addr, exp_addr);
        if (exp_we) chk(mem_wdata == exp_wdata, req, "mem_wdata", mem_wdata, exp_wdata);
        for (int i = 0; i < int'($urandom % 4); i++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == exp_addr && mem_we == exp_we, "R8", "hold addr",
                mem_addr, exp_addr);
        end
        mem_rdata = rd;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = $urandom;
    endtask

    task automatic run_case(bit sgn, logic [DW-1:0] a, logic [DW-1:0] b, bit hold_issue);
        logic [DW-1:0] pc  = $urandom & 32'hFFFF_FFFE;
        logic [DW-1:0] sr  = $urandom;
        logic [DW-1:0] sp  = ($urandom & 32'h00FF_FFFC) | 32'h0000_0010;
        logic [DW-1:0] vb  = $urandom & 32'hFFFF_FC00;
        logic [DW-1:0] hnd = $urandom & 32'hFFFF_FFFE;
        bit trap = expect_trap(sgn, a, b);
        issue_valid = 1'b1; issue_signed = sgn; dividend = a; divisor = b;
        insn_addr = pc; sr_in = sr; sp_in = sp; vec_base = vb;
        @(negedge clk);
        if (!hold_issue) issue_valid = 1'b0;
        else divisor = '0;
        sr_in = $urandom; sp_in = $urandom; insn_addr = $urandom; vec_base = $urandom;
        if (!trap) begin
            for (int i = 0; i < 2; i++) begin
                chk(!busy && !mem_req && !pc_load && !sp_we,
                    (b == 32'hFFFF_FFFF && a == 32'h8000_0000) ? "R2" : "R3",
                    "quiet", {28'd0, busy, mem_req, pc_load, sp_we}, 32'd0);
                @(negedge clk);
            end
            return;
        end
        chk(busy == 1'b1, (b == '0) ? "R1" : "R2", "busy after detect", 32'(busy), 32'd1);
        serve(1'b0, vb + 32'(VEC * 4), '0, hnd, "R4");
        chk(busy && !pc_load, "R9", "busy mid", {30'd0, busy, pc_load}, 32'd2);
        serve(1'b1, sp - 32'd4, sr, $urandom, "R5");
        serve(1'b1, sp - 32'd8, pc, $urandom, "R6");
        chk(pc_load == 1'b1, "R7", "pc_load", 32'(pc_load), 32'd1);
        chk(pc_value == hnd, "R7", "pc_value", pc_value, hnd);
        chk(sp_we == 1'b1, "R7", "sp_we", 32'(sp_we), 32'd1);
        chk(sp_out == sp - 32'd8, "R7", "sp_out", sp_out, sp - 32'd8);
        chk(busy == 1'b1, "R9", "busy at load", 32'(busy), 32'd1);
        issue_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !pc_load && !mem_req, "R9", "idle after load",
            {29'd0, busy, pc_load, mem_req}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !pc_load && !sp_we, "R10", "reset state",
            {28'd0, busy, mem_req, pc_load, sp_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        run_case(1'b0, 32'd77, 32'd0, 1'b0);              // R1 unsigned zero
        run_case(1'b1, 32'hFFFF_FF00, 32'd0, 1'b0);       // R1 signed zero
        run_case(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R2 signed overflow
        run_case(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R2 unsigned no trap
        run_case(1'b1, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0); // R3 near miss
        run_case(1'b1, 32'h8000_0000, 32'hFFFF_FFFE, 1'b0); // R3 near miss
        run_case(1'b0, 32'd10, 32'd3, 1'b0);              // R3 ordinary
        run_case(1'b1, 32'd5, 32'd0, 1'b1);               // R9 issue held while busy
        for (int k = 0; k < 300; k++) begin
            int sel = int'($urandom % 8);
            bit s = 1'($urandom);
            logic [DW-1:0] a = $urandom;
            logic [DW-1:0] b = $urandom;
            if (sel < 2) b = '0;
            else if (sel == 2) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
            run_case(s, a, b, 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule